// File: doc/BRIEF.md
# Tile Register Matrix Unit

This execution unit serves a small matrix extension of a scalar core. It keeps eight tile registers, each a 4x4 array of 32-bit signed integers, and executes one already-decoded command at a time. A command can clear a tile, fill a tile from memory, write a tile back to memory, or accumulate the product of two tiles into a third tile, with the first source used in transposed form.

Memory traffic goes through one 32-bit word port with a valid/ready handshake. Loads and stores walk the tile row by row. Words within a row are adjacent. The start address of each row is the previous row's start plus a byte stride that the issuing core supplies. The scalar core cannot read tile contents directly: data leaves a tile only through a store.

The core sees the unit through `busy` and `done`. The multiply-accumulate uses one multiplier and one adder and computes one output element every four cycles. It collects all sixteen results before it writes them to the destination, so the destination may be the same tile as either source.

Top module: `tile_mxu`

## Requirements
- R1: Reset clears all eight tiles to zero and leaves `busy`, `done` and `mem_valid` low.
- R2: A command is taken only on a cycle with `start` high and `busy` low, and `busy` is high on the next cycle. The encodings of `cmd_op` are 0 = zero, 1 = load, 2 = store, 3 = multiply-accumulate. A `start` asserted while `busy` is high has no effect.
- R3: `done` is high for exactly one cycle per command. It rises on the same cycle that `busy` falls.
- R4: The zero command sets all 16 elements of tile `cmd_md` to 0.
- R5: The load command reads 16 words into tile `cmd_md` in row-major order. Element (r,c) comes from byte address `cmd_base + r*cmd_stride + 4*c`, and element index r*4+c holds row r, column c.
- R6: The store command writes the 16 elements of tile `cmd_md` to memory with the same address pattern and order as the load, with `mem_we` high.
- R7: When `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold steady and no element is skipped.
- R8: The multiply-accumulate command sets md[i][j] = md[i][j] + sum over k of ms2[i][k]*ms1[j][k]. In this command, md is `cmd_md`, ms1 is `cmd_ms1` and ms2 is `cmd_ms2`.
- R9: Products and sums wrap modulo 2^32, with no saturation.
- R10: The multiply-accumulate gives the correct result when the destination tile is the same as ms1 or ms2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request |
| cmd_op | input | 2 | Command kind |
| cmd_md | input | 3 | Destination tile (also the tile for zero, load and store) |
| cmd_ms1 | input | 3 | First source tile, used transposed |
| cmd_ms2 | input | 3 | Second source tile |
| cmd_base | input | 32 | Byte address of row 0 for load/store |
| cmd_stride | input | 32 | Byte distance between row starts |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid on this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets aliasing first, with destination equal to ms1 and then to ms2. A unit that wrote elements back one at a time would feed partly updated values into later products. Non-transposed use of ms1 is caught by loading non-symmetric tiles, where the wrong operand order gives a different product. Irregular row strides and random `mem_ready` stalls expose a unit that advances its address on a stalled cycle or skips a row; overflowing operands expose saturation. A `start` pulse during a running load checks that a second command cannot slip in and zero the tile.

// File: rtl/tmx_pkg.sv
// Shared definitions for the tile matrix unit.
// Assumes a power-of-two tile dimension and tile count.
package tmx_pkg;
    localparam int unsigned TMX_DATA_W = 32;
    localparam int unsigned TMX_ADDR_W = 32;
    localparam int unsigned TMX_TILES  = 8;
    localparam int unsigned TMX_DIM    = 4;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_MAC   = 2'd3
    } tmx_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_XFER,
        ST_MAC,
        ST_COMMIT
    } tmx_state_e;
endpackage

// File: rtl/tmx_tile_file.sv
// Tile storage: N_TILES tiles of ELEMS words each.
// One single-element write port (loads), one whole-tile write port (zero, MAC commit),
// three asynchronous element read ports. The two write ports are never used together.
module tmx_tile_file #(
    parameter  int DATA_W  = 32,
    parameter  int N_TILES = 8,
    parameter  int ELEMS   = 16,
    localparam int TW      = $clog2(N_TILES),
    localparam int EW      = $clog2(ELEMS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    el_we,
    input  logic [TW-1:0]           el_tile,
    input  logic [EW-1:0]           el_idx,
    input  logic [DATA_W-1:0]       el_data,
    input  logic                    all_we,
    input  logic [TW-1:0]           all_tile,
    input  logic [ELEMS*DATA_W-1:0] all_data,
    input  logic [TW-1:0]           ra_tile,
    input  logic [EW-1:0]           ra_idx,
    output logic [DATA_W-1:0]       ra_data,
    input  logic [TW-1:0]           rb_tile,
    input  logic [EW-1:0]           rb_idx,
    output logic [DATA_W-1:0]       rb_data,
    input  logic [TW-1:0]           rc_tile,
    input  logic [EW-1:0]           rc_idx,
    output logic [DATA_W-1:0]       rc_data
);
    logic [DATA_W-1:0] cell_q [N_TILES][ELEMS];

    // Storage update: clear on reset, whole-tile write wins over element write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TILES; t++)
                for (int e = 0; e < ELEMS; e++)
                    cell_q[t][e] <= '0;
        end else if (all_we) begin
            for (int e = 0; e < ELEMS; e++)
                cell_q[all_tile][e] <= all_data[e*DATA_W +: DATA_W];
        end else if (el_we) begin
            cell_q[el_tile][el_idx] <= el_data;
        end
    end

    assign ra_data = cell_q[ra_tile][ra_idx];
    assign rb_data = cell_q[rb_tile][rb_idx];
    assign rc_data = cell_q[rc_tile][rc_idx];
endmodule

// File: rtl/tmx_mac_core.sv
// Sequential multiply-accumulate: one multiplier, one adder, one product per step.
// A step with 'first' seeds the sum with md_val; a step with 'last' parks the sum in
// the result buffer at elem_idx. Arithmetic wraps at DATA_W bits.
module tmx_mac_core #(
    parameter  int DATA_W = 32,
    parameter  int ELEMS  = 16,
    localparam int EW     = $clog2(ELEMS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    first,
    input  logic                    last,
    input  logic [EW-1:0]           elem_idx,
    input  logic [DATA_W-1:0]       md_val,
    input  logic [DATA_W-1:0]       a_val,
    input  logic [DATA_W-1:0]       b_val,
    output logic [ELEMS*DATA_W-1:0] result_flat
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] res_q [ELEMS];
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] sum;

    assign prod = a_val * b_val;
    assign sum  = (first ? md_val : acc_q) + prod;

    // Accumulator and result buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            for (int e = 0; e < ELEMS; e++) res_q[e] <= '0;
        end else if (step_en) begin
            acc_q <= sum;
            if (last) res_q[elem_idx] <= sum;
        end
    end

    for (genvar g = 0; g < ELEMS; g++) begin : g_flat
        assign result_flat[g*DATA_W +: DATA_W] = res_q[g];
    end
endmodule

// File: rtl/tile_mxu.sv
// Tile matrix unit top: command sequencer, strided address walker, tile file, MAC core.
// Assumes mem_rdata is valid in the cycle mem_valid && mem_ready, and DIM a power of two.
module tile_mxu
    import tmx_pkg::*;
#(
    parameter  int DATA_W  = TMX_DATA_W,
    parameter  int ADDR_W  = TMX_ADDR_W,
    parameter  int N_TILES = TMX_TILES,
    parameter  int DIM     = TMX_DIM,
    localparam int TW      = $clog2(N_TILES),
    localparam int ELEMS   = DIM * DIM,
    localparam int EW      = $clog2(ELEMS),
    localparam int KW      = $clog2(DIM),
    localparam int BSH     = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cmd_op,
    input  logic [TW-1:0]     cmd_md,
    input  logic [TW-1:0]     cmd_ms1,
    input  logic [TW-1:0]     cmd_ms2,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    output logic              busy,
    output logic              done,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    tmx_state_e        state_q;
    tmx_op_e           op_q;
    logic [TW-1:0]     md_q, s1_q, s2_q;
    logic [ADDR_W-1:0] stride_q, row_addr_q;
    logic [EW-1:0]     idx_q;
    logic [KW-1:0]     k_q;
    logic              done_q;

    logic [KW-1:0]     row_i, col_j;
    logic              idx_last, k_last, col_last;
    logic [DATA_W-1:0] ra_data, rb_data, rc_data;
    logic [ELEMS*DATA_W-1:0] mac_result, all_data;
    logic              all_we, el_we;

    assign row_i    = idx_q[EW-1:KW];
    assign col_j    = idx_q[KW-1:0];
    assign idx_last = (idx_q == EW'(ELEMS - 1));
    assign k_last   = (k_q == KW'(DIM - 1));
    assign col_last = (col_j == KW'(DIM - 1));

    // Command sequencer: latches a command when idle, walks elements, pulses done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_ZERO;
            md_q       <= '0;
            s1_q       <= '0;
            s2_q       <= '0;
            stride_q   <= '0;
            row_addr_q <= '0;
            idx_q      <= '0;
            k_q        <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    op_q       <= tmx_op_e'(cmd_op);
                    md_q       <= cmd_md;
                    s1_q       <= cmd_ms1;
                    s2_q       <= cmd_ms2;
                    stride_q   <= cmd_stride;
                    row_addr_q <= cmd_base;
                    idx_q      <= '0;
                    k_q        <= '0;
                    case (tmx_op_e'(cmd_op))
                        OP_ZERO: state_q <= ST_ZERO;
                        OP_MAC:  state_q <= ST_MAC;
                        default: state_q <= ST_XFER;
                    endcase
                end
                ST_ZERO: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                ST_XFER: if (mem_ready) begin
                    idx_q <= idx_q + 1'b1;
                    if (col_last) row_addr_q <= row_addr_q + stride_q;
                    if (idx_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_MAC: begin
                    k_q <= k_q + 1'b1;
                    if (k_last) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_last) state_q <= ST_COMMIT;
                    end
                end
                ST_COMMIT: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port and status outputs.
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign mem_valid = (state_q == ST_XFER);
    assign mem_we    = mem_valid && (op_q == OP_STORE);
    assign mem_addr  = row_addr_q + (ADDR_W'(col_j) << BSH);
    assign mem_wdata = ra_data;

    assign el_we    = mem_valid && mem_ready && (op_q == OP_LOAD);
    assign all_we   = (state_q == ST_ZERO) || (state_q == ST_COMMIT);
    assign all_data = (state_q == ST_ZERO) ? '0 : mac_result;

    tmx_tile_file #(
        .DATA_W (DATA_W),
        .N_TILES(N_TILES),
        .ELEMS  (ELEMS)
    ) u_tiles (
        .clk     (clk),
        .rst_n   (rst_n),
        .el_we   (el_we),
        .el_tile (md_q),
        .el_idx  (idx_q),
        .el_data (mem_rdata),
        .all_we  (all_we),
        .all_tile(md_q),
        .all_data(all_data),
        .ra_tile (md_q),
        .ra_idx  (idx_q),
        .ra_data (ra_data),
        .rb_tile (s2_q),
        .rb_idx  ({row_i, k_q}),
        .rb_data (rb_data),
        .rc_tile (s1_q),
        .rc_idx  ({col_j, k_q}),
        .rc_data (rc_data)
    );

    tmx_mac_core #(
        .DATA_W(DATA_W),
        .ELEMS (ELEMS)
    ) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (state_q == ST_MAC),
        .first      (k_q == '0),
        .last       (k_last),
        .elem_idx   (idx_q),
        .md_val     (ra_data),
        .a_val      (rb_data),
        .b_val      (rc_data),
        .result_flat(mac_result)
    );
endmodule

// File: rtl/tmx_checker.sv
// Protocol checker for tile_mxu, attached by bind. Observes ports only.
module tmx_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy); // R2
    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R3
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R7
    AST_STALL_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && !mem_ready |=> $stable(mem_wdata)); // R7
endmodule

bind tile_mxu tmx_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tmx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_valid(mem_valid),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/test_tile_mxu.sv
// Scoreboard bench: driver tasks queue expected memory transactions from a bench-side
// tile model; a monitor pops and compares each handshake on the memory port.
module test_tile_mxu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_md = '0, cmd_ms1 = '0, cmd_ms2 = '0;
    logic [31:0] cmd_base = '0, cmd_stride = '0;
    logic        busy, done, mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    typedef struct {bit we; logic [31:0] addr; logic [31:0] data;} exp_t;
    exp_t        exp_q[$];
    logic [31:0] mem_arr [256];
    logic [31:0] model [8][16];
    logic [15:0] lfsr = 16'hACE1;
    bit          stall_mode = 1'b0;
    string       cur_tag = "R1";
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    assign mem_rdata = mem_arr[mem_addr[9:2]];

    tile_mxu i_tile_mxu (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op),
        .cmd_md(cmd_md), .cmd_ms1(cmd_ms1), .cmd_ms2(cmd_ms2),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .busy(busy), .done(done), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: set ready for this cycle, then compare any handshake against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            mem_ready = stall_mode ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected access", mem_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_we == e.we, cur_tag, "access kind", 32'(mem_we), 32'(e.we));
                    check(mem_addr == e.addr, cur_tag, "address", mem_addr, e.addr);
                    if (e.we)
                        check(mem_wdata == e.data, cur_tag, "store data", mem_wdata, e.data);
                end
                if (mem_we) mem_arr[mem_addr[9:2]] = mem_wdata;
            end
        end
    end

    // Issue one command, optionally poking start while busy, then check the done pulse.
    task automatic run_cmd(input logic [1:0] op, input int md, input int s1, input int s2,
                           input logic [31:0] base, input logic [31:0] stride, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1; cmd_op = op; cmd_md = 3'(md); cmd_ms1 = 3'(s1); cmd_ms2 = 3'(s2);
        cmd_base = base; cmd_stride = stride;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'h1);
        if (poke) begin
            start = 1'b1; cmd_op = 2'd0;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(busy == 1'b0, "R3", "busy low with done", 32'(busy), 32'h0);
        @(negedge clk);
        check(done == 1'b0, "R3", "done lasts one cycle", 32'(done), 32'h0);
    endtask

    task automatic do_load(input int t, input logic [31:0] base, input logic [31:0] stride,
                           input bit poke);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                logic [31:0] a;
                a = base + 32'(r) * stride + 32'(4 * c);
                model[t][r*4+c] = mem_arr[a[9:2]];
                exp_q.push_back('{1'b0, a, 32'h0});
            end
        run_cmd(2'd1, t, 0, 0, base, stride, poke);
    endtask

    task automatic do_store(input int t, input logic [31:0] base, input logic [31:0] stride);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                exp_q.push_back('{1'b1, base + 32'(r) * stride + 32'(4 * c), model[t][r*4+c]});
        run_cmd(2'd2, t, 0, 0, base, stride, 1'b0);
    endtask

    task automatic do_zero(input int t);
        for (int e = 0; e < 16; e++) model[t][e] = '0;
        run_cmd(2'd0, t, 0, 0, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic do_mac(input int d, input int s1, input int s2);
        logic [31:0] nv [16];
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                logic [31:0] acc;
                acc = model[d][i*4+j];
                for (int k = 0; k < 4; k++)
                    acc = acc + model[s2][i*4+k] * model[s1][j*4+k];
                nv[i*4+j] = acc;
            end
        for (int e = 0; e < 16; e++) model[d][e] = nv[e];
        run_cmd(2'd3, d, s1, s2, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int w = 0; w < 256; w++) mem_arr[w] = 32'(w * 7 - 50);
        for (int w = 192; w < 208; w++) mem_arr[w] = 32'h7FFF_FFF0 + 32'(w * 3);
        for (int t = 0; t < 8; t++)
            for (int e = 0; e < 16; e++) model[t][e] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'h0);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", 32'(mem_valid), 32'h0);

        cur_tag = "R1"; do_store(3, 32'h380, 32'd16); do_store(7, 32'h380, 32'd16);
        cur_tag = "R5"; do_load(0, 32'h0, 32'd16, 1'b0); do_load(1, 32'h40, 32'd32, 1'b0);
        cur_tag = "R7"; stall_mode = 1'b1;
        do_load(2, 32'h100, 32'd64, 1'b0); do_store(2, 32'h200, 32'd20);
        stall_mode = 1'b0;
        cur_tag = "R6"; do_store(0, 32'h200, 32'd24); do_store(1, 32'h200, 32'd16);
        cur_tag = "R8"; do_mac(4, 1, 0); do_store(4, 32'h200, 32'd16);
        do_mac(4, 2, 1); do_store(4, 32'h200, 32'd16);
        cur_tag = "R9"; do_load(5, 32'h300, 32'd16, 1'b0); do_mac(6, 5, 5);
        do_store(6, 32'h200, 32'd16);
        cur_tag = "R10"; do_mac(0, 0, 1); do_store(0, 32'h200, 32'd16);
        do_mac(1, 0, 1); do_store(1, 32'h200, 32'd16);
        cur_tag = "R4"; do_zero(4); do_store(4, 32'h200, 32'd16);
        cur_tag = "R2"; do_load(3, 32'h0, 32'd16, 1'b1); do_store(3, 32'h200, 32'd16);
        check(exp_q.size() == 0, "R6", "all expected accesses seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule